// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit with Extend Chaining

This unit performs decimal arithmetic on packed binary-coded-decimal operands, two decimal digits per byte by default. It can add two operands together with the extend flag, subtract one operand and the extend flag from the other, or take the decimal ten's-complement of an operand less the extend flag. Each accepted operation returns a corrected decimal result one clock later, together with updated extend, zero and carry flags.

Long decimal numbers are processed one byte at a time, starting with the least significant byte. The extend flag carries the decimal carry or borrow from one byte into the next. The zero flag is never set by an operation. It is only cleared when a result is nonzero, so after a chain it says whether every byte of the long result was zero. Before a chain starts, the owner loads the flags (usually X=0 and Z=1) through a dedicated load strobe. Addressing, operand fetch and write-back belong to the surrounding datapath.

Top module: `bcd_xarith`

## Requirements
- R1: While reset is asserted, and after it is released, res_valid=0, res_bcd=0, x_flag=0, c_flag=0 and z_flag=1.
- R2: op_code 2'b00 (add) with op_valid=1 produces res_bcd = (src + dst + X) mod 100 in decimal. res_valid pulses high in the cycle after the operation is accepted.
- R3: op_code 2'b01 (subtract) produces res_bcd = (dst − src − X) mod 100 in decimal, with the same timing as R2.
- R4: op_code 2'b10 (negate) produces res_bcd = (0 − dst − X) mod 100 in decimal, and src_bcd has no effect.
- R5: After each operation, c_flag is 1 exactly when a decimal carry (add) or borrow (subtract, negate) leaves the upper digit, and 0 otherwise.
- R6: After each operation, x_flag equals c_flag.
- R7: After an operation, z_flag is 0 if the result is nonzero. Otherwise z_flag keeps its previous value.
- R8: flag_ld=1 loads x_flag from flag_ld_x and z_flag from flag_ld_z, and clears c_flag, at the next edge. Any operation presented in the same cycle is dropped, with no res_valid.
- R9: op_code 2'b11 is reserved. An operation with this code gives no res_valid and leaves res_bcd and all flags unchanged.
- R10: A chain of byte operations, least significant byte first, gives the correct multi-byte decimal result. z_flag remains 1 at the end only if every result byte was zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 add, 01 subtract, 10 negate, 11 reserved |
| src_bcd | input | 4*NDIGITS | Source operand, packed decimal |
| dst_bcd | input | 4*NDIGITS | Destination operand, packed decimal |
| flag_ld | input | 1 | Flag load strobe, takes priority over op_valid |
| flag_ld_x | input | 1 | Value loaded into x_flag |
| flag_ld_z | input | 1 | Value loaded into z_flag |
| res_valid | output | 1 | Result valid pulse |
| res_bcd | output | 4*NDIGITS | Registered decimal result |
| x_flag | output | 1 | Extend flag |
| z_flag | output | 1 | Sticky zero flag |
| c_flag | output | 1 | Decimal carry/borrow flag |

## Verification
The bench targets the digit-correction corners: sums that pass 9 without a nibble overflow (45+38), sums that ripple a carry through both digits (99+01), and subtractions that borrow through a zero (00−00−X giving 99). A design that corrected only on nibble overflow, or took the carry from the binary sum, would return non-decimal digits or a wrong C/X. Chained runs check that a stale X or a Z that can be set again would show up as a wrong final Z or a wrong upper byte. The bench also confirms that negate ignores src, and that a load or a reserved code in the same cycle as an operation drops that operation.

// File: rtl/bcd_xarith_pkg.sv
package bcd_xarith_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_RSV = 2'b11
  } bcd_op_e;
endpackage

// File: rtl/bcd_digit_cell.sv
// One decimal digit: binary add/subtract then decimal correction by 6.
module bcd_digit_cell (
  input  logic       sub_mode,
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] y,
  output logic       cout
);
  logic [4:0] raw;

  always_comb begin
    if (sub_mode) begin
      raw  = {1'b0, a} - {1'b0, b} - {4'b0, cin};
      cout = raw[4];
      y    = raw[4] ? (raw[3:0] - 4'd6) : raw[3:0];
    end else begin
      raw  = {1'b0, a} + {1'b0, b} + {4'b0, cin};
      cout = (raw > 5'd9);
      y    = cout ? (raw[3:0] + 4'd6) : raw[3:0];
    end
  end
endmodule

// File: rtl/bcd_digit_chain.sv
// Ripple of digit cells; carry/borrow travels low digit to high digit.
module bcd_digit_chain #(
  parameter int NDIGITS = 2
) (
  input  logic                   sub_mode,
  input  logic [4*NDIGITS-1:0]   a,
  input  logic [4*NDIGITS-1:0]   b,
  input  logic                   cin,
  output logic [4*NDIGITS-1:0]   y,
  output logic                   cout
);
  logic [NDIGITS:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < NDIGITS; g++) begin : g_digit
    bcd_digit_cell u_cell (
      .sub_mode (sub_mode),
      .a        (a[4*g +: 4]),
      .b        (b[4*g +: 4]),
      .cin      (carry[g]),
      .y        (y[4*g +: 4]),
      .cout     (carry[g+1])
    );
  end

  assign cout = carry[NDIGITS];
endmodule

// File: rtl/bcd_xarith_flags.sv
// X/Z/C state: load has priority, Z only ever cleared by an update.
module bcd_xarith_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_en,
  input  logic ld_x,
  input  logic ld_z,
  input  logic upd_en,
  input  logic carry,
  input  logic res_zero,
  output logic x_q,
  output logic z_q,
  output logic c_q
);
  logic x_d, z_d, c_d;
  logic flag_en;

  always_comb begin
    x_d = x_q;
    z_d = z_q;
    c_d = c_q;
    if (ld_en) begin
      x_d = ld_x;
      z_d = ld_z;
      c_d = 1'b0;
    end else if (upd_en) begin
      x_d = carry;
      c_d = carry;
      z_d = z_q & res_zero;
    end
  end

  assign flag_en = ld_en | upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= 1'b0;
      z_q <= 1'b1;
      c_q <= 1'b0;
    end else if (flag_en) begin
      x_q <= x_d;
      z_q <= z_d;
      c_q <= c_d;
    end
  end
endmodule

// File: rtl/bcd_xarith.sv
module bcd_xarith
  import bcd_xarith_pkg::*;
#(
  parameter int NDIGITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [1:0]           op_code,
  input  logic [4*NDIGITS-1:0] src_bcd,
  input  logic [4*NDIGITS-1:0] dst_bcd,
  input  logic                 flag_ld,
  input  logic                 flag_ld_x,
  input  logic                 flag_ld_z,
  output logic                 res_valid,
  output logic [4*NDIGITS-1:0] res_bcd,
  output logic                 x_flag,
  output logic                 z_flag,
  output logic                 c_flag
);
  localparam int W = 4 * NDIGITS;

  bcd_op_e        op;
  logic           accept;
  logic           sub_mode;
  logic [W-1:0]   opa, opb;
  logic [W-1:0]   sum;
  logic           carry;
  logic           vld_d;
  logic [W-1:0]   res_d;

  assign op = bcd_op_e'(op_code);

  // operand steering: negate is subtract from zero
  always_comb begin
    accept   = op_valid & ~flag_ld & (op != OP_RSV);
    sub_mode = (op != OP_ADD);
    opa      = dst_bcd;
    opb      = src_bcd;
    if (op == OP_NEG) begin
      opa = '0;
      opb = dst_bcd;
    end
  end

  bcd_digit_chain #(.NDIGITS(NDIGITS)) u_chain (
    .sub_mode (sub_mode),
    .a        (opa),
    .b        (opb),
    .cin      (x_flag),
    .y        (sum),
    .cout     (carry)
  );

  bcd_xarith_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (flag_ld),
    .ld_x     (flag_ld_x),
    .ld_z     (flag_ld_z),
    .upd_en   (accept),
    .carry    (carry),
    .res_zero (sum == '0),
    .x_q      (x_flag),
    .z_q      (z_flag),
    .c_q      (c_flag)
  );

  always_comb begin
    vld_d = accept;
    res_d = accept ? sum : res_bcd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_bcd   <= '0;
    end else begin
      res_valid <= vld_d;
      if (accept) res_bcd <= res_d;
    end
  end
endmodule

// File: rtl/bcd_xarith_chk.sv
module bcd_xarith_chk #(
  parameter int NDIGITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic [1:0]           op_code,
  input logic [4*NDIGITS-1:0] src_bcd,
  input logic [4*NDIGITS-1:0] dst_bcd,
  input logic                 flag_ld,
  input logic                 flag_ld_x,
  input logic                 flag_ld_z,
  input logic                 res_valid,
  input logic [4*NDIGITS-1:0] res_bcd,
  input logic                 x_flag,
  input logic                 z_flag,
  input logic                 c_flag
);
  assert_accept_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_ld && op_code != 2'b11) |=> res_valid);

  assert_x_tracks_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (x_flag == c_flag));

  assert_z_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_bcd != '0) |-> !z_flag);

  assert_z_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_ld && op_code != 2'b11 && !z_flag) |=> !z_flag);

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> (!res_valid && !c_flag && x_flag == $past(flag_ld_x)
                 && z_flag == $past(flag_ld_z)));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_ld && op_code == 2'b11) |=>
      (!res_valid && $stable(res_bcd) && $stable(x_flag)
       && $stable(z_flag) && $stable(c_flag)));
endmodule

bind bcd_xarith bcd_xarith_chk #(.NDIGITS(NDIGITS)) u_chk (.*);

// File: tb/bcd_xarith_tb.sv
`timescale 1ns/1ps
module bcd_xarith_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, flag_ld, flag_ld_x, flag_ld_z;
  logic [1:0] op_code;
  logic [7:0] src_bcd, dst_bcd, res_bcd;
  logic       res_valid, x_flag, z_flag, c_flag;

  always #4 clk = ~clk;

  bcd_xarith u_dut (.*);

  typedef struct {
    logic [7:0] res;
    logic x, z, c;
    string tag;
  } exp_t;
  exp_t q[$];

  int  n_tests = 0, n_fail = 0;
  logic mx = 1'b0, mz = 1'b1, mc = 1'b0;

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // driver: one op per call, expectation pushed to scoreboard
  task automatic do_op(logic [1:0] op, logic [7:0] s, logic [7:0] d, string tag);
    int r;
    logic cy;
    @(negedge clk);
    op_valid = 1'b1; flag_ld = 1'b0;
    op_code = op; src_bcd = s; dst_bcd = d;
    cy = 1'b0;
    if (op == 2'b00) begin
      r = b2i(s) + b2i(d) + int'(mx);
      if (r >= 100) begin r -= 100; cy = 1'b1; end
    end else begin
      r = (op == 2'b01 ? b2i(d) - b2i(s) : 0 - b2i(d)) - int'(mx);
      if (r < 0) begin r += 100; cy = 1'b1; end
    end
    mx = cy; mc = cy; mz = mz & (r == 0);
    q.push_back('{res: i2b(r), x: mx, z: mz, c: mc, tag: tag});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0; flag_ld = 1'b0;
    end
  endtask

  task automatic load(logic lx, logic lz, logic with_op);
    @(negedge clk);
    flag_ld = 1'b1; flag_ld_x = lx; flag_ld_z = lz;
    op_valid = with_op; op_code = 2'b00; src_bcd = 8'h11; dst_bcd = 8'h22;
    mx = lx; mz = lz; mc = 1'b0;
    @(negedge clk);
    flag_ld = 1'b0; op_valid = 1'b0;
    check("R8 x", x_flag, lx);
    check("R8 z", z_flag, lz);
    check("R8 c", c_flag, 0);
    check("R8 no result", res_valid, 0);
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        check("R9 unexpected res_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " result"}, res_bcd, e.res);
        check("R5 c_flag", c_flag, e.c);
        check("R6 x_flag", x_flag, e.x);
        check("R7 z_flag", z_flag, e.z);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    logic [7:0] keep_res;
    rst_n = 1'b0; op_valid = 1'b0; flag_ld = 1'b0; flag_ld_x = 1'b0;
    flag_ld_z = 1'b0; op_code = 2'b00; src_bcd = '0; dst_bcd = '0;
    repeat (3) @(negedge clk);
    check("R1 res_valid", res_valid, 0);
    check("R1 res_bcd", res_bcd, 0);
    check("R1 x", x_flag, 0);
    check("R1 z", z_flag, 1);
    check("R1 c", c_flag, 0);
    rst_n = 1'b1;

    // add corners
    do_op(2'b00, 8'h45, 8'h38, "R2 add 45+38");
    do_op(2'b00, 8'h99, 8'h01, "R2 add 99+01");
    do_op(2'b00, 8'h00, 8'h00, "R2 add with X");
    do_op(2'b00, 8'h50, 8'h49, "R2 add 99");
    // subtract corners
    do_op(2'b01, 8'h27, 8'h52, "R3 sub 52-27");
    do_op(2'b01, 8'h20, 8'h10, "R3 sub borrow");
    do_op(2'b01, 8'h00, 8'h00, "R3 sub 00-00-X");
    // negate, src must not matter
    do_op(2'b10, 8'h77, 8'h01, "R4 neg 01");
    do_op(2'b10, 8'h33, 8'h00, "R4 neg 00 with X");
    idle(2);
    load(1'b0, 1'b1, 1'b0);
    do_op(2'b10, 8'h99, 8'h00, "R4 neg 00 no X");
    do_op(2'b10, 8'h00, 8'h99, "R4 neg 99");
    for (int i = 0; i < 60; i++)
      do_op(2'($urandom_range(0, 2)), i2b($urandom_range(0, 99)),
            i2b($urandom_range(0, 99)), "R2 R3 R4 random");
    idle(3);

    // reserved code ignored
    keep_res = res_bcd;
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'b11; src_bcd = 8'h12; dst_bcd = 8'h34;
    @(negedge clk);
    op_valid = 1'b0;
    check("R9 res_valid", res_valid, 0);
    check("R9 res_bcd", res_bcd, keep_res);
    check("R9 x", x_flag, mx);
    check("R9 z", z_flag, mz);
    check("R9 c", c_flag, mc);

    // load with simultaneous op: op dropped
    load(1'b1, 1'b0, 1'b1);
    idle(1);

    // chain: 99999999 + 00000001 = 00000000 carry 1, Z stays 1
    load(1'b0, 1'b1, 1'b0);
    do_op(2'b00, 8'h01, 8'h99, "R10 chain b0");
    do_op(2'b00, 8'h00, 8'h99, "R10 chain b1");
    do_op(2'b00, 8'h00, 8'h99, "R10 chain b2");
    do_op(2'b00, 8'h00, 8'h99, "R10 chain b3");
    idle(2);
    check("R10 zero chain z", z_flag, 1);
    check("R10 zero chain c", c_flag, 1);

    // chain: 12345678 - 00345679 = 11999999, Z must end 0
    load(1'b0, 1'b1, 1'b0);
    do_op(2'b01, 8'h79, 8'h78, "R10 sub chain b0");
    do_op(2'b01, 8'h56, 8'h56, "R10 sub chain b1");
    do_op(2'b01, 8'h34, 8'h34, "R10 sub chain b2");
    do_op(2'b01, 8'h00, 8'h12, "R10 sub chain b3");
    idle(2);
    check("R10 sub chain top byte", res_bcd, 8'h11);
    check("R10 sub chain z", z_flag, 0);
    check("R10 sub chain c", c_flag, 0);

    idle(3);
    check("R2 scoreboard drained", q.size(), 0);
    summary();
  end
endmodule